// File: doc/BRIEF.md
# Dual-Select Static RAM Array

This block is a 256-word by 4-bit storage array. It has an 8-bit address, a 4-bit write bus and a separate 4-bit read bus. Four control lines set its mode: an active-low select, an active-high select, an output-disable line and a read/write line. Logic decodes them into one of four modes: standby, output-disabled, read or write.

The three-state output driver is modelled as a 4-bit data value plus an enable flag. The data value is forced to zero whenever the enable is low, so results compare deterministically. The block is clocked, and all results are registered. Mode, enable and data appear one cycle after the address and controls are presented. A write is committed on the same rising edge. A 2-bit mode output reports which decode was taken, so the decode can be observed at the ports.

When input and output share a wire, output-disable is held high during a write so the block does not drive. When the buses are separate, a write with output-disable low drives the incoming word straight back out.

Top module: `dsel_sram`

## Requirements
- R1: While reset is low and in the first cycle after it, `mode` is 2'b00, `dout_en` is 0 and `dout` is 0.
- R2: If `sel_n` is 1 or `sel` is 0, the next cycle shows `mode` 2'b00 (standby) and `dout_en` 0, whatever `out_dis`, `rd_wr_n`, `addr` and `din` are.
- R3: If `out_dis` is 1, the next cycle shows `dout_en` 0, whatever the select inputs are.
- R4: With `sel_n`=0, `sel`=1, `out_dis`=0 and `rd_wr_n`=1, the next cycle shows `mode` 2'b10, `dout_en` 1 and `dout` equal to the word stored at `addr`.
- R5: With `sel_n`=0, `sel`=1 and `rd_wr_n`=0, `din` is stored at `addr` on that clock edge and the next cycle shows `mode` 2'b11.
- R6: During a write with `out_dis`=0, the next cycle shows `dout_en` 1 and `dout` equal to the `din` that was written.
- R7: During a write with `out_dis`=1, the word is still stored, and the next cycle shows `dout_en` 0.
- R8: In standby (with either value of `rd_wr_n`) and in output-disabled mode, no stored word changes.
- R9: A read from an address written on the previous edge returns the new word.
- R10: Whenever `dout_en` is 0, `dout` is 0.
- R11: The mode code is 2'b00 standby, 2'b01 output-disabled, 2'b10 read and 2'b11 write. Selection is decoded first, then `rd_wr_n`, then `out_dis`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| out_dis | input | 1 | Output disable, active high |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| dout | output | 4 | Output word, zero when not driving |
| dout_en | output | 1 | Output driver enable |
| mode | output | 2 | Decoded mode code |

## Verification
Every result (`mode`, `dout_en` and `dout`) is due exactly one rising edge after its stimulus. A stored word becomes visible to a read one edge after the write edge. The bench changes inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Back-to-back write-then-read steps check that the stored word is visible without an extra cycle. Reads issued after standby or disabled cycles that carried write-like stimulus check that nothing changed.

// File: rtl/dsel_sram.sv
module dsel_sram #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          out_dis,
  input  logic          rd_wr_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [1:0]    mode
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] M_STBY = 2'b00;
  localparam logic [1:0] M_ODIS = 2'b01;
  localparam logic [1:0] M_RD   = 2'b10;
  localparam logic [1:0] M_WR   = 2'b11;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    mode_d;
  logic          en_d;
  logic [DW-1:0] dout_d;
  wire           picked = !sel_n && sel;

  always_comb begin
    if (!picked)       mode_d = M_STBY;
    else if (!rd_wr_n) mode_d = M_WR;
    else if (out_dis)  mode_d = M_ODIS;
    else               mode_d = M_RD;
  end

  assign en_d   = (mode_d == M_RD) || (mode_d == M_WR && !out_dis);
  assign dout_d = (mode_d == M_RD) ? mem[addr] :
                  (en_d ? din : '0);

  always_ff @(posedge clk)
    if (mode_d == M_WR) mem[addr] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= M_STBY;
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      mode    <= mode_d;
      dout_en <= en_d;
      dout    <= dout_d;
    end

  a_r10_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);
  a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |=> (mode == 2'b00 && !dout_en));
  a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |=> !dout_en);
  a_r5_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !rd_wr_n) |=> mode == 2'b11);
  a_r6_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !rd_wr_n && !out_dis) |=> (dout_en && dout == $past(din)));
  a_r4_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && rd_wr_n && !out_dis) |=> (mode == 2'b10 && dout_en));
endmodule

// File: tb/dsel_sram_tb.sv
module dsel_sram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic       sel_n = 1'b1, sel = 1'b0, out_dis = 1'b0, rd_wr_n = 1'b1;
  logic [3:0] dout;
  logic       dout_en;
  logic [1:0] mode;
  int total = 0, bad = 0;
  logic [3:0] shadow [256];

  always #4 clk = ~clk;

  dsel_sram dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .sel_n(sel_n),
    .sel(sel), .out_dis(out_dis), .rd_wr_n(rd_wr_n), .dout(dout), .dout_en(dout_en),
    .mode(mode));

  // {sel_n, sel, out_dis, rd_wr_n, mode[1:0], en}
  localparam logic [6:0] VEC [16] = '{
    7'b0000_00_0, 7'b0001_00_0, 7'b0010_00_0, 7'b0011_00_0,
    7'b0100_11_1, 7'b0101_10_1, 7'b0110_11_0, 7'b0111_01_0,
    7'b1000_00_0, 7'b1001_00_0, 7'b1010_00_0, 7'b1011_00_0,
    7'b1100_00_0, 7'b1101_00_0, 7'b1110_00_0, 7'b1111_00_0};

  task automatic chk(string req, logic [3:0] ed, logic ee, logic [1:0] em);
    total++;
    if (dout !== ed || dout_en !== ee || mode !== em) begin
      bad++;
      $display("FAIL %s: dout=%h en=%b mode=%b expected dout=%h en=%b mode=%b",
               req, dout, dout_en, mode, ed, ee, em);
    end
  endtask

  task automatic drive(logic [3:0] c, logic [7:0] a, logic [3:0] d);
    {sel_n, sel, out_dis, rd_wr_n} = c;
    addr = a;
    din = d;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'h0, 1'b0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 4'h0, 1'b0, 2'b00);

    // preload through R5 writes, output echoes din (R6)
    for (int a = 0; a < 256; a++) begin
      shadow[a] = a[3:0] ^ a[7:4];
      drive(4'b0100, a[7:0], shadow[a]);
      if (a % 37 == 0) chk("R6 preload echo", shadow[a], 1'b1, 2'b11);
    end

    // table walk over every control combination (R2 R3 R4 R11)
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      logic [3:0] d;
      logic [3:0] ed;
      a = 8'(i * 17 + 3);
      d = 4'(i) ^ 4'h9;
      if (VEC[i][2:1] == 2'b10) ed = shadow[a];
      else if (VEC[i][0]) ed = d;
      else ed = 4'h0;
      drive(VEC[i][6:3], a, d);
      if (VEC[i][2:1] == 2'b11) shadow[a] = d;
      chk($sformatf("R11 R2 R3 R4 decode vec %0d", i), ed, VEC[i][0], VEC[i][2:1]);
    end

    // R7: write with output disabled stores silently, then read back (R4)
    drive(4'b0110, 8'h5A, 4'hC);
    chk("R7 write hidden", 4'h0, 1'b0, 2'b11);
    drive(4'b0101, 8'h5A, 4'h0);
    chk("R7 stored word", 4'hC, 1'b1, 2'b10);

    // R9: back-to-back write then read same address
    drive(4'b0100, 8'hF0, 4'h7);
    chk("R6 echo", 4'h7, 1'b1, 2'b11);
    drive(4'b0101, 8'hF0, 4'h0);
    chk("R9 read after write", 4'h7, 1'b1, 2'b10);

    // R8: standby with rd_wr_n=0 and disabled mode leave memory untouched
    drive(4'b1000, 8'h21, 4'hE);
    chk("R8 standby write ignored", 4'h0, 1'b0, 2'b00);
    drive(4'b0010, 8'h21, 4'hE);
    chk("R8 deselect write ignored", 4'h0, 1'b0, 2'b00);
    drive(4'b0111, 8'h21, 4'hE);
    chk("R10 disabled output zero", 4'h0, 1'b0, 2'b01);
    drive(4'b0101, 8'h21, 4'h0);
    chk("R8 word unchanged", shadow[8'h21], 1'b1, 2'b10);

    // R3: disable over read gives zero (R10)
    drive(4'b0111, 8'hF0, 4'h0);
    chk("R3 disable over read", 4'h0, 1'b0, 2'b01);

    // R1: reset mid-run clears outputs
    drive(4'b0101, 8'hF0, 4'h0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 4'h0, 1'b0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b0101, 8'hF0, 4'h0);
    chk("R4 read after reset", 4'h7, 1'b1, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule